// File: doc/BRIEF.md
# Actuator Homing Sequencer

This block runs the positioning routine a piezo actuator needs after it is switched on. When the enable input goes high, it drives the actuator's waveform generator through three phases. The first is an outgoing move of a programmed number of step periods. The second is a fixed pause of four step periods, with the drive held off. The third is a return move of a programmed number of step periods in the opposite direction. After the return move the block rests in standby.

The block controls the generator with a one-cycle start strobe for each step period. It also drives a direction line and a drive-enable line that tells the generator whether to produce a real waveform or an idle period. The generator answers each period with a one-cycle `period_done` pulse, and the block counts these pulses. A `busy` output stays high for the whole routine, including the pause. A software-controlled bit can turn the routine off, in which case enabling the block leads straight to standby.

Top module: `homing_sequencer`

## Requirements
- R1: When `en` rises and `seq_enable` is 1, `busy` and `step_start` are both high in the cycle after the rising edge is sampled.
- R2: `step_dir` encodes 0 = toward infinity and 1 = toward macro. The outgoing move uses the value of `dir_sel` captured at the rising edge of `en`. The return move uses the inverse of that captured value. Changes to `dir_sel` during the routine have no effect.
- R3: The outgoing move issues exactly `init_count` strobes with `drive_en` = 1. Each strobe after the first is issued only after a `period_done` pulse.
- R4: The pause issues exactly 4 strobes with `drive_en` = 0.
- R5: The return move issues exactly `ret_count` strobes with `drive_en` = 1 and the opposite direction. All of these strobes come after every outgoing strobe.
- R6: Every strobe occurs while `busy` is high. After the final `period_done`, `busy` falls and no further strobe occurs while `en` stays high.
- R7: If `seq_enable` is 0 when `en` rises, the block goes to standby with `busy` low and issues no strobe.
- R8: When `en` is low, the next cycle has `busy`, `drive_en` and `step_start` all low. This also holds when a `period_done` pulse arrives in the same cycle.
- R9: An `init_count` or `ret_count` of zero skips that move. The pause still occurs.
- R10: While `rst_n` is low, `busy`, `drive_en` and `step_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; a rising edge starts the routine, a low level aborts it |
| dir_sel | input | 1 | Outgoing direction: 0 infinity, 1 macro |
| seq_enable | input | 1 | 1 runs the routine on enable, 0 goes straight to standby |
| init_count | input | CNT_W | Step periods in the outgoing move |
| ret_count | input | CNT_W | Step periods in the return move |
| period_done | input | 1 | One-cycle pulse from the generator when a period ends |
| step_start | output | 1 | One-cycle strobe that starts one generator period |
| step_dir | output | 1 | Direction for the period being started |
| drive_en | output | 1 | 1 for a driven period, 0 for an idle pause period |
| busy | output | 1 | High for the whole routine |

## Verification
Two events can land in the same cycle: the abort caused by `en` falling, and the end of a period that would otherwise hand over to the next phase or issue another strobe. The bench waits for a cycle in which the generator model shows `period_done` high. It drops `en` in that same cycle. It then requires `busy`, `drive_en` and `step_start` to be low one cycle later, and no strobe to appear afterward. The phase handovers are also exercised with zero counts, so that the pause follows the rising edge directly or leads straight to standby.

// File: rtl/hs_pkg.sv
// Package hs_pkg
// Shared types for the homing sequencer.
package hs_pkg;
    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,
        HS_OUT     = 3'd1,
        HS_PAUSE   = 3'd2,
        HS_BACK    = 3'd3,
        HS_STANDBY = 3'd4
    } hs_state_e;
endpackage

// File: rtl/hs_rise_detect.sv
// Module hs_rise_detect
// Produces a one-cycle pulse when a level input changes from 0 to 1.
// Assumes the input is already synchronous to clk.
module hs_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Hold the previous level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/hs_period_counter.sv
// Module hs_period_counter
// Counts the step periods left in the current phase.
// The counter is loaded at phase entry and decremented on each tick.
// Assumes the controller only ticks while a phase is running.
module hs_period_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          last
);
    // Remaining-period register: clear has priority, then load, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (load)  count <= load_val;
        else if (tick)  count <= count - 1'b1;
    end

    assign last = (count == {{(CW-1){1'b0}}, 1'b1});

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (count != '0));
endmodule

// File: rtl/homing_sequencer.sv
// Module homing_sequencer
// Runs the power-up routine: an outgoing move, a fixed pause, then a return
// move in the opposite direction, followed by standby.
// Assumes the generator returns exactly one period_done pulse for each strobe.
module homing_sequencer
    import hs_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int WAIT_PERIODS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_sel,
    input  logic             seq_enable,
    input  logic [CNT_W-1:0] init_count,
    input  logic [CNT_W-1:0] ret_count,
    input  logic             period_done,
    output logic             step_start,
    output logic             step_dir,
    output logic             drive_en,
    output logic             busy
);
    localparam int WAIT_W = $clog2(WAIT_PERIODS + 1);
    localparam int CW     = (CNT_W > WAIT_W) ? CNT_W : WAIT_W;
    localparam logic [CW-1:0] WAIT_VAL = CW'(WAIT_PERIODS);

    hs_state_e       state_q, state_d;
    logic            dir_q;
    logic            start_q, start_d;
    logic            rise;
    logic            cnt_clear, cnt_load, cnt_tick, cnt_last;
    logic [CW-1:0]   cnt_val, cnt_q;
    logic            running;

    hs_rise_detect i_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (en),
        .rise  (rise)
    );

    hs_period_counter #(.CW(CW)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (cnt_tick),
        .count    (cnt_q),
        .last     (cnt_last)
    );

    assign running  = (state_q == HS_OUT) || (state_q == HS_PAUSE) || (state_q == HS_BACK);
    assign cnt_tick = en && running && period_done;

    // Next-state logic: phase handover, counter loads and strobe requests.
    always_comb begin
        state_d   = state_q;
        start_d   = 1'b0;
        cnt_clear = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        if (!en) begin
            state_d   = HS_IDLE;
            cnt_clear = 1'b1;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (rise) begin
                        if (!seq_enable) begin
                            state_d = HS_STANDBY;
                        end else if (init_count != '0) begin
                            state_d  = HS_OUT;
                            cnt_load = 1'b1;
                            cnt_val  = CW'(init_count);
                            start_d  = 1'b1;
                        end else begin
                            state_d  = HS_PAUSE;
                            cnt_load = 1'b1;
                            cnt_val  = WAIT_VAL;
                            start_d  = 1'b1;
                        end
                    end
                end
                HS_OUT: begin
                    if (cnt_tick) begin
                        start_d = 1'b1;
                        if (cnt_last) begin
                            state_d  = HS_PAUSE;
                            cnt_load = 1'b1;
                            cnt_val  = WAIT_VAL;
                        end
                    end
                end
                HS_PAUSE: begin
                    if (cnt_tick) begin
                        if (!cnt_last) begin
                            start_d = 1'b1;
                        end else if (ret_count != '0) begin
                            state_d  = HS_BACK;
                            cnt_load = 1'b1;
                            cnt_val  = CW'(ret_count);
                            start_d  = 1'b1;
                        end else begin
                            state_d   = HS_STANDBY;
                            cnt_clear = 1'b1;
                        end
                    end
                end
                HS_BACK: begin
                    if (cnt_tick) begin
                        if (cnt_last) begin
                            state_d   = HS_STANDBY;
                            cnt_clear = 1'b1;
                        end else begin
                            start_d = 1'b1;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
        end
    end

    // Capture the outgoing direction when the routine starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= 1'b0;
        else if (state_q == HS_IDLE && rise) dir_q <= dir_sel;
    end

    assign step_start = start_q;
    assign busy       = running;
    assign drive_en   = (state_q == HS_OUT) || (state_q == HS_BACK);
    assign step_dir   = (state_q == HS_BACK) ? ~dir_q : dir_q;

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && seq_enable) |=> (busy && step_start));

    p_seq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && !seq_enable) |=> (!busy && !step_start));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !drive_en && !step_start));

    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |-> busy);

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir_q));
endmodule

// File: tb/test_homing_sequencer.sv
// Bench for homing_sequencer: a vector table walked by one loop, then
// directed tests for reset, abort and direction capture.
module test_homing_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int GEN_P      = 3;
    localparam int NVEC       = 8;

    // Vector fields: {dir, seq_enable, init[3:0], ret[3:0]}
    localparam logic [9:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 4'd3,  4'd2},
        {1'b1, 1'b1, 4'd5,  4'd1},
        {1'b0, 1'b1, 4'd0,  4'd3},
        {1'b1, 1'b1, 4'd2,  4'd0},
        {1'b0, 1'b1, 4'd0,  4'd0},
        {1'b1, 1'b0, 4'd4,  4'd4},
        {1'b0, 1'b1, 4'd15, 4'd15},
        {1'b1, 1'b1, 4'd1,  4'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             dir_sel = 1'b0;
    logic             seq_enable = 1'b0;
    logic [CNT_W-1:0] init_count = '0;
    logic [CNT_W-1:0] ret_count = '0;
    logic             period_done;
    logic             step_start, step_dir, drive_en, busy;
    int               gen_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int fwd, rev, pauses, unbusy, order_err;
    logic rev_seen, cur_dir;

    homing_sequencer #(.CNT_W(CNT_W), .WAIT_PERIODS(4)) i_homing_sequencer (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_sel(dir_sel),
        .seq_enable(seq_enable), .init_count(init_count), .ret_count(ret_count),
        .period_done(period_done), .step_start(step_start), .step_dir(step_dir),
        .drive_en(drive_en), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Generator model: answers each strobe with a done pulse GEN_P cycles later.
    always @(posedge clk) begin
        if (!rst_n || !en) begin
            gen_cnt     <= 0;
            period_done <= 1'b0;
        end else begin
            period_done <= (gen_cnt == 1);
            if (step_start)      gen_cnt <= GEN_P;
            else if (gen_cnt != 0) gen_cnt <= gen_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts(input logic d);
        fwd = 0; rev = 0; pauses = 0; unbusy = 0; order_err = 0;
        rev_seen = 1'b0; cur_dir = d;
    endtask

    // Advance to the next falling edge and classify any strobe seen there.
    task automatic step_sample();
        @(negedge clk);
        if (step_start) begin
            if (!busy) unbusy++;
            if (drive_en) begin
                if (step_dir == cur_dir) begin
                    fwd++;
                    if (rev_seen) order_err++;
                end else begin
                    rev++;
                    rev_seen = 1'b1;
                end
            end else begin
                pauses++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10: outputs idle while reset is held.
        repeat (3) @(negedge clk);
        check(!busy && !drive_en && !step_start, "R10", {busy, drive_en, step_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table loop: R1 R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            int win;
            logic d, s;
            d = VECS[v][9];
            s = VECS[v][8];
            en = 1'b0;
            repeat (3) @(negedge clk);
            dir_sel    = d;
            seq_enable = s;
            init_count = VECS[v][7:4];
            ret_count  = VECS[v][3:0];
            clear_counts(d);
            en = 1'b1;
            step_sample();
            check(busy == s && step_start == s, s ? "R1" : "R7",
                  {busy, step_start}, {s, s});
            win = (int'(VECS[v][7:4]) + int'(VECS[v][3:0]) + 4) * (GEN_P + 3) + 30;
            for (int c = 0; c < win; c++) step_sample();
            check(fwd == (s ? int'(VECS[v][7:4]) : 0), "R3 R9", fwd, s ? int'(VECS[v][7:4]) : 0);
            check(pauses == (s ? 4 : 0), "R4", pauses, s ? 4 : 0);
            check(rev == (s ? int'(VECS[v][3:0]) : 0), "R5 R2", rev, s ? int'(VECS[v][3:0]) : 0);
            check(order_err == 0, "R5", order_err, 0);
            check(unbusy == 0 && !busy, "R6", unbusy + int'(busy), 0);
        end

        // R2: a change of dir_sel mid-routine must not alter the captured direction.
        en = 1'b0;
        repeat (3) @(negedge clk);
        dir_sel = 1'b0; seq_enable = 1'b1; init_count = 4'd4; ret_count = 4'd2;
        clear_counts(1'b0);
        en = 1'b1;
        for (int c = 0; c < 6; c++) step_sample();
        dir_sel = 1'b1;
        for (int c = 0; c < 80; c++) step_sample();
        check(fwd == 4, "R2", fwd, 4);
        check(rev == 2, "R2", rev, 2);

        // R8: drop en in the same cycle a period_done pulse is present.
        en = 1'b0;
        repeat (3) @(negedge clk);
        dir_sel = 1'b1; init_count = 4'd10; ret_count = 4'd2;
        clear_counts(1'b1);
        en = 1'b1;
        for (int c = 0; c < 40 && !period_done; c++) step_sample();
        check(period_done == 1'b1 && busy, "R8", {period_done, busy}, 3);
        en = 1'b0;
        clear_counts(1'b1);
        step_sample();
        check(!busy && !drive_en && !step_start, "R8", {busy, drive_en, step_start}, 0);
        for (int c = 0; c < 30; c++) step_sample();
        check(fwd + rev + pauses == 0, "R8", fwd + rev + pauses, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule